// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Address-Marker Bit

This block turns bytes into asynchronous serial frames on a single output line. Software or a DMA channel loads a holding register. The block moves that value into a shift register and sends it one bit per baud tick. The baud tick comes from a divider outside the block.

Two flags report progress. The holding-empty flag shows that the holding register can take another byte. The line-finished flag shows that the last frame's stop bit has gone out with nothing waiting behind it. An optional addressing format adds one extra bit to each frame, after the data bits. Receivers use that bit to tell address frames from data frames. Its value comes from a software-written control bit.

A small capture register on the receive side keeps the addressing bit of the most recent received frame. A receiver outside the block presents that bit together with a one-cycle valid pulse.

The DMA channel is a valid/ready stream. A byte is taken on a cycle where `dma_valid` and `dma_ready` are both high. `dma_ready` is low while the holding register is occupied, and the source must then hold `dma_valid` and `dma_data` steady. Receive capture has no back-pressure: every `rx_valid` pulse is examined in its own cycle.

Top module: `sertx_mp`

## Requirements
- R1: After reset, `txd` is 1, the control register (address 1) reads 0 and the status register (address 2) reads 0x84. Status bits are: bit 7 holding-empty, bit 2 line-finished, bit 1 captured address bit, bit 0 transmit address bit.
- R2: While `tx_en` (control bit 0) is 0 or `standby` is 1, line-finished is forced to 1 from the next cycle, any frame in progress is abandoned and `txd` returns to 1.
- R3: When the stop bit ends at a bit tick while holding-empty is 1, line-finished becomes 1.
- R4: `dma_ready` equals holding-empty. An accepted DMA beat loads the holding register and clears both holding-empty and line-finished.
- R5: A status write (address 2) with bit 7 at 0 clears holding-empty and line-finished only if a status read saw holding-empty as 1 since it last became 1. Such a write without that read changes neither flag.
- R6: The frame is a start bit of 0, then the data bits least significant first, then the optional address bit, then a stop bit of 1. Each bit ends at the clock edge where `bit_tick` is 1.
- R7: The address bit is sent only when control bit 2 (address format) is 1 and control bit 3 (synchronous select) is 0. Its value is status bit 0, sampled when the frame is loaded. Otherwise the frame has no extra bit.
- R8: On an `rx_valid` pulse, the captured address bit loads `rx_mpb`, but only while control bit 1 (receive enable) is 1, address format is 1 and synchronous select is 0. Otherwise it keeps its value.
- R9: When the transmitter is enabled and idle and holding-empty is 0, the next clock edge loads the shift register. It sets holding-empty and drives `txd` to 0.
- R10: When holding-empty is 0 at the tick that ends a stop bit, the next start bit follows at once, with no idle bit period.
- R11: If a DMA beat is accepted in the same cycle that a stop bit ends with holding-empty at 1, line-finished stays 0. The new byte is then sent as the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read arms the flag clear) |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| dma_valid | input | 1 | DMA beat valid |
| dma_data | input | DATA_W | DMA beat payload |
| dma_ready | output | 1 | Holding register can take a beat |
| bit_tick | input | 1 | One-cycle baud tick that ends the current bit |
| standby | input | 1 | Low-power request; abandons transmission |
| rx_valid | input | 1 | A received frame's address bit is presented |
| rx_mpb | input | 1 | Address bit of the received frame |
| txd | output | 1 | Serial output line, idle high |

## Verification
The end of a stop bit with nothing pending, which sets line-finished, can fall in the same cycle as a DMA beat, which clears it. The bench holds the baud tick under manual control, so it knows exactly which tick ends the stop bit, and raises `dma_valid` together with that tick. It then checks that line-finished stays 0 right after the edge, that the line goes low for a new start bit one cycle later, and that the new byte decodes correctly. The same bench model also runs randomly chosen bytes, address bits, formats and load paths, decoding every frame from the line.

// File: rtl/sertx_mp_pkg.sv
package sertx_mp_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  // status bit positions
  localparam int unsigned SB_EMPTY = 7;
  localparam int unsigned SB_TEND  = 2;
  localparam int unsigned SB_MPB   = 1;
  localparam int unsigned SB_MPBT  = 0;

  localparam int unsigned CTRL_W = 4;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_START,
    SH_DATA,
    SH_MP,
    SH_STOP
  } sh_state_e;

  // control register layout, bit 0 at the right
  typedef struct packed {
    logic sync;
    logic mp_fmt;
    logic rx_en;
    logic tx_en;
  } ctrl_t;
endpackage

// File: rtl/sertx_mp_shifter.sv
module sertx_mp_shifter
  import sertx_mp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              pend,
  input  logic              mp_on,
  input  logic              mp_val,
  input  logic [DATA_W-1:0] load_data,
  output logic              take,
  output logic              done_idle,
  output logic              txd
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  sh_state_e         st_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              mpv_q;
  logic              mpo_q;
  logic              txd_q;
  logic              stop_end;

  assign stop_end  = en && tick && (st_q == SH_STOP);
  assign take      = en && pend && ((st_q == SH_IDLE) || stop_end);
  assign done_idle = stop_end && !pend;
  assign txd       = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SH_IDLE;
      sh_q  <= '0;
      cnt_q <= '0;
      mpv_q <= 1'b0;
      mpo_q <= 1'b0;
      txd_q <= 1'b1;
    end else if (!en) begin
      st_q  <= SH_IDLE;
      txd_q <= 1'b1;
    end else if (take) begin
      st_q  <= SH_START;
      txd_q <= 1'b0;
      sh_q  <= load_data;
      mpv_q <= mp_val;
      mpo_q <= mp_on;
      cnt_q <= '0;
    end else if (tick) begin
      case (st_q)
        SH_START: begin
          st_q  <= SH_DATA;
          txd_q <= sh_q[0];
          sh_q  <= sh_q >> 1;
          cnt_q <= '0;
        end
        SH_DATA: begin
          if (cnt_q == LAST) begin
            if (mpo_q) begin
              st_q  <= SH_MP;
              txd_q <= mpv_q;
            end else begin
              st_q  <= SH_STOP;
              txd_q <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
            txd_q <= sh_q[0];
            sh_q  <= sh_q >> 1;
          end
        end
        SH_MP: begin
          st_q  <= SH_STOP;
          txd_q <= 1'b1;
        end
        default: begin
          st_q  <= SH_IDLE;
          txd_q <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/sertx_mp_rxcap.sv
module sertx_mp_rxcap (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic rx_valid,
  input  logic rx_mpb,
  output logic mpb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 mpb <= 1'b0;
    else if (rx_valid && cap_en) mpb <= rx_mpb;
  end
endmodule

// File: rtl/sertx_mp_regs.sv
module sertx_mp_regs
  import sertx_mp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dma_valid,
  input  logic [DATA_W-1:0] dma_data,
  output logic              dma_ready,
  input  logic              standby,
  input  logic              take,
  input  logic              done_idle,
  input  logic              mpb,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] tdr,
  output logic              mpbt,
  output logic              empty,
  output logic              tend
);
  logic stat_rd, stat_wr, sw_clr, dma_acc, armed_q, line_off;
  logic [DATA_W-1:0] stat_v;

  assign stat_rd   = reg_rd && (reg_addr == A_STAT);
  assign stat_wr   = reg_wr && (reg_addr == A_STAT);
  assign sw_clr    = stat_wr && !reg_wdata[SB_EMPTY] && armed_q && empty;
  assign dma_ready = empty;
  assign dma_acc   = dma_valid && empty;
  assign line_off  = !ctrl.tx_en || standby;

  always_comb begin
    stat_v          = '0;
    stat_v[SB_EMPTY] = empty;
    stat_v[SB_TEND]  = tend;
    stat_v[SB_MPB]   = mpb;
    stat_v[SB_MPBT]  = mpbt;
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = tdr;
      A_CTRL:  reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
      A_STAT:  reg_rdata = stat_v;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      tdr     <= '0;
      mpbt    <= 1'b0;
      empty   <= 1'b1;
      tend    <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      if (reg_wr && (reg_addr == A_CTRL)) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (stat_wr) mpbt <= reg_wdata[SB_MPBT];

      if (dma_acc)                             tdr <= dma_data;
      else if (reg_wr && (reg_addr == A_DATA)) tdr <= reg_wdata;

      if (take)                   empty <= 1'b1;
      else if (sw_clr || dma_acc) empty <= 1'b0;

      if (take || sw_clr || dma_acc || !empty) armed_q <= 1'b0;
      else if (stat_rd)                        armed_q <= 1'b1;

      if (line_off)               tend <= 1'b1;
      else if (sw_clr || dma_acc) tend <= 1'b0;
      else if (done_idle)         tend <= 1'b1;
    end
  end
endmodule

// File: rtl/sertx_mp.sv
module sertx_mp
  import sertx_mp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dma_valid,
  input  logic [DATA_W-1:0] dma_data,
  output logic              dma_ready,
  input  logic              bit_tick,
  input  logic              standby,
  input  logic              rx_valid,
  input  logic              rx_mpb,
  output logic              txd
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] tdr_w;
  logic              mpbt_w, empty_w, tend_w, mpb_w;
  logic              take_w, done_w, en_w, mp_on_w, cap_en_w;
  logic              tx_en_w, rx_en_w;

  assign tx_en_w  = ctrl_q.tx_en;
  assign rx_en_w  = ctrl_q.rx_en;
  assign en_w     = ctrl_q.tx_en && !standby;
  assign mp_on_w  = ctrl_q.mp_fmt && !ctrl_q.sync;
  assign cap_en_w = ctrl_q.rx_en && mp_on_w;

  sertx_mp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_valid(dma_valid), .dma_data(dma_data), .dma_ready(dma_ready),
    .standby(standby), .take(take_w), .done_idle(done_w), .mpb(mpb_w),
    .ctrl(ctrl_q), .tdr(tdr_w), .mpbt(mpbt_w), .empty(empty_w), .tend(tend_w)
  );

  sertx_mp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(en_w), .tick(bit_tick), .pend(!empty_w),
    .mp_on(mp_on_w), .mp_val(mpbt_w), .load_data(tdr_w),
    .take(take_w), .done_idle(done_w), .txd(txd)
  );

  sertx_mp_rxcap u_rxcap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en_w),
    .rx_valid(rx_valid), .rx_mpb(rx_mpb), .mpb(mpb_w)
  );
endmodule

// File: rtl/sertx_mp_chk.sv
module sertx_mp_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic rx_en,
  input logic standby,
  input logic dma_valid,
  input logic dma_ready,
  input logic empty,
  input logic tend,
  input logic mpb,
  input logic txd
);
  AST_TEND_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || standby) |=> tend); // R2
  AST_LINE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || standby) |=> txd); // R2
  AST_DMA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && dma_ready && tx_en && !standby) |=> (!tend && !empty)); // R4
  AST_MPB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(mpb)); // R8
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> !txd); // R9
endmodule

bind sertx_mp sertx_mp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en_w), .rx_en(rx_en_w),
  .standby(standby), .dma_valid(dma_valid), .dma_ready(dma_ready),
  .empty(empty_w), .tend(tend_w), .mpb(mpb_w), .txd(txd)
);

// File: tb/sertx_mp_bench.sv
module sertx_mp_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] d;
    logic       mp;
    logic       has;
  } frame_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  wire  [7:0] reg_rdata;
  logic       dma_valid = 1'b0;
  logic [7:0] dma_data = 8'd0;
  wire        dma_ready;
  logic       standby = 1'b0, rx_valid = 1'b0, rx_mpb = 1'b0;
  wire        txd;
  wire        bit_tick;
  logic       auto_on = 1'b0, man_tick = 1'b0;
  logic [1:0] div = 2'd0;

  int n_err = 0, n_chk = 0;
  frame_t exp_q[$];
  frame_t cur;
  logic dec_off = 1'b0;
  logic in_fr = 1'b0;
  int pos = 0, gap = 0, last_gap = 0, frames_done = 0;
  logic [9:0] bits;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) div <= (div == 2'd2) ? 2'd0 : div + 2'd1;
  assign bit_tick = auto_on ? (div == 2'd2) : man_tick;

  sertx_mp u_sertx_mp (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_valid(dma_valid), .dma_data(dma_data), .dma_ready(dma_ready),
    .bit_tick(bit_tick), .standby(standby), .rx_valid(rx_valid),
    .rx_mpb(rx_mpb), .txd(txd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int frame_len(input frame_t f);
    return 9 + (f.has ? 1 : 0);
  endfunction

  // line decoder built from the frame format
  always @(negedge clk) begin
    if (dec_off || !rst_n) begin
      in_fr = 1'b0;
      gap = 0;
    end else if (bit_tick) begin
      if (!in_fr) begin
        if (txd == 1'b0) begin
          last_gap = gap;
          gap = 0;
          pos = 0;
          if (exp_q.size() == 0) chk(0, "R6 unexpected frame", 1, 0);
          else begin
            cur = exp_q.pop_front();
            in_fr = 1'b1;
          end
        end else gap++;
      end else begin
        bits[pos] = txd;
        pos++;
        if (pos == frame_len(cur)) begin
          in_fr = 1'b0;
          frames_done++;
          chk(bits[7:0] == cur.d, "R6 data bits", int'(bits[7:0]), int'(cur.d));
          if (cur.has) chk(bits[8] == cur.mp, "R7 address bit", int'(bits[8]), int'(cur.mp));
          chk(bits[pos-1] == 1'b1, "R6 R7 stop position", int'(bits[pos-1]), 1);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic peek(output logic [7:0] d);
    reg_addr = 2'd2;
    #1 d = reg_rdata;
  endtask

  task automatic set_ctrl(input bit te, input bit re, input bit mp, input bit sy);
    wr(2'd1, {4'b0, sy, mp, re, te});
  endtask

  task automatic wait_empty();
    logic [7:0] s;
    do rd(2'd2, s); while (!s[7]);
  endtask

  task automatic send_sw(input logic [7:0] d, input bit mp, input bit has);
    logic [7:0] s;
    frame_t f;
    wait_empty();
    wr(2'd0, d);
    rd(2'd2, s);
    f.d = d; f.mp = mp; f.has = has;
    exp_q.push_back(f);
    wr(2'd2, {7'b0, mp});
  endtask

  task automatic send_dma(input logic [7:0] d, input bit mp, input bit has);
    logic r;
    frame_t f;
    wait_empty();
    wr(2'd2, {1'b1, 6'b0, mp});
    f.d = d; f.mp = mp; f.has = has;
    exp_q.push_back(f);
    dma_valid = 1'b1; dma_data = d;
    do begin
      @(negedge clk); r = dma_ready;
      @(posedge clk); #1;
    end while (!r);
    dma_valid = 1'b0;
  endtask

  task automatic mtick();
    man_tick = 1'b1; step();
    man_tick = 1'b0; step();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    peek(s);
    while (!s[2] || exp_q.size() != 0) begin
      step();
      peek(s);
    end
  endtask

  task automatic rxp(input bit b);
    rx_valid = 1'b1; rx_mpb = b;
    step();
    rx_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] s;
    int base_frames;
    bit model_mpb;
    repeat (4) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    peek(s);
    chk(s == 8'h84, "R1 status after reset", s, 8'h84);
    chk(txd == 1'b1, "R1 line idle", txd, 1);
    rd(2'd1, s);
    chk(s == 8'h00, "R1 control after reset", s, 0);

    // R5 clear without prior read is ignored
    wr(2'd2, 8'h00);
    peek(s);
    chk(s[7] && s[2], "R5 write without read ignored", s, 8'h84);

    // R9, R11 with manual ticks
    set_ctrl(1, 1, 0, 0);
    wr(2'd0, 8'hA5);
    rd(2'd2, s);
    exp_q.push_back('{d: 8'hA5, mp: 1'b0, has: 1'b0});
    wr(2'd2, 8'h00);
    peek(s);
    chk(!s[7] && !s[2], "R5 armed clear", s, 8'h00);
    step();
    peek(s);
    chk(txd == 1'b0 && s[7], "R9 load and start bit", {txd, s[7]}, 2'b01);
    repeat (9) mtick();
    man_tick = 1'b1; dma_valid = 1'b1; dma_data = 8'h3C;
    exp_q.push_back('{d: 8'h3C, mp: 1'b0, has: 1'b0});
    step();
    man_tick = 1'b0; dma_valid = 1'b0;
    peek(s);
    chk(!s[2] && !s[7], "R11 clear wins over end", s, 8'h00);
    step();
    chk(txd == 1'b0, "R11 new frame starts", txd, 0);
    repeat (10) mtick();
    peek(s);
    chk(s[2] == 1'b1, "R3 line finished after last stop", s[2], 1);
    chk(frames_done == 2, "R11 both frames decoded", frames_done, 2);

    // R4 DMA path, R10 back-to-back with address bit, auto ticks
    auto_on = 1'b1;
    set_ctrl(1, 1, 1, 0);
    send_dma(8'h96, 1'b1, 1'b1);
    peek(s);
    chk(!s[2] && !s[7] && !dma_ready, "R4 dma accept clears flags", s, 0);
    send_sw(8'h11, 1'b0, 1'b1);
    send_sw(8'h22, 1'b1, 1'b1);
    wait_idle();
    chk(last_gap == 0, "R10 no idle gap", last_gap, 0);

    // R7 synchronous select suppresses address bit
    set_ctrl(1, 1, 1, 1);
    send_sw(8'h77, 1'b1, 1'b0);
    wait_idle();
    set_ctrl(1, 1, 0, 0);
    send_sw(8'h0F, 1'b1, 1'b0);
    wait_idle();

    // R8 receive capture
    set_ctrl(1, 1, 1, 0);
    rxp(1'b1); peek(s);
    chk(s[1] == 1'b1, "R8 capture loads", s[1], 1);
    set_ctrl(1, 0, 1, 0);
    rxp(1'b0); peek(s);
    chk(s[1] == 1'b1, "R8 held with receive off", s[1], 1);
    set_ctrl(1, 1, 0, 0);
    rxp(1'b0); peek(s);
    chk(s[1] == 1'b1, "R8 held with format off", s[1], 1);
    set_ctrl(1, 1, 1, 0);
    rxp(1'b0); peek(s);
    chk(s[1] == 1'b0, "R8 capture loads zero", s[1], 0);

    // R2 disable and standby abandon a frame
    set_ctrl(1, 1, 0, 0);
    send_sw(8'h55, 1'b0, 1'b0);
    repeat (12) step();
    dec_off = 1'b1;
    set_ctrl(0, 1, 0, 0);
    step(); peek(s);
    chk(s[2] && txd, "R2 disable ends frame", {s[2], txd}, 2'b11);
    exp_q.delete();
    dec_off = 1'b0;
    set_ctrl(1, 1, 0, 0);
    send_sw(8'h66, 1'b0, 1'b0);
    repeat (12) step();
    dec_off = 1'b1;
    standby = 1'b1;
    step(); step(); peek(s);
    chk(s[2] && txd, "R2 standby ends frame", {s[2], txd}, 2'b11);
    standby = 1'b0;
    exp_q.delete();
    dec_off = 1'b0;

    // random phase
    void'($urandom(32'd2718));
    model_mpb = 1'b0;
    base_frames = frames_done;
    for (int blk = 0; blk < 5; blk++) begin
      bit mp, sy;
      wait_idle();
      mp = 1'($urandom % 2);
      sy = 1'($urandom % 2);
      set_ctrl(1, 1, mp, sy);
      for (int k = 0; k < 8; k++) begin
        logic [7:0] d;
        bit m;
        d = 8'($urandom);
        m = 1'($urandom % 2);
        if ($urandom % 3 == 0) begin
          bit b;
          b = 1'($urandom % 2);
          rxp(b);
          if (mp && !sy) model_mpb = b;
        end
        if ($urandom % 2 == 0) send_sw(d, m, mp && !sy);
        else send_dma(d, m, mp && !sy);
      end
    end
    wait_idle();
    peek(s);
    chk(s[2] == 1'b1, "R3 finished after random run", s[2], 1);
    chk(s[1] == model_mpb, "R8 captured bit after random run", s[1], model_mpb);
    chk(frames_done - base_frames == 40, "R6 random frame count", frames_done - base_frames, 40);
    finish_run();
  end
endmodule